// File: doc/BRIEF.md
# Fault Status and Escalation Unit

This block sits beside a processor core model and turns single-cycle fault events into the number of the exception the core should take. The core reports undefined opcodes, illegal state changes, bad exception-return tokens, coprocessor use, misaligned accesses, integer division by zero, memory-protection violations (instruction side, data side, and during context save or restore), bus error responses, and attempts by unprivileged code to touch the system control space. Each event sets a sticky status flag. One registered cycle later, the unit presents the exception number to raise.

Three fault classes can be configured: memory-protection, bus and usage. Each class has its own enable bit. An event in an enabled class raises that class's own exception. An event in a disabled class is promoted to the fixed hard fault. Division by zero is special: it counts as an event only while a separate trap bit is set. Otherwise the divide completes silently.

Software reaches the unit through a small register port. Status flags are cleared by writing 1 to them. On a data-side protection violation, the unit captures the faulting address and keeps it until software clears the address-valid flag.

Top module: `fault_escalator`

## Requirements
- R1: After reset, all status flags, the captured address, the trap bit and the three enables read 0, and `exc_valid` is 0.
- R2: Usage status (register address 0) sets bit 0 on an undefined opcode, bit 1 on an invalid state, bit 2 on an invalid return token, bit 3 on coprocessor use and bit 8 on a misaligned access. The flags become visible in the cycle after the event.
- R3: A divide-by-zero event sets usage status bit 9 and counts as a usage fault only while the trap bit (bit 4 of address 4) is 1. While the trap bit is 0, the event changes no status flag and raises no exception.
- R4: Protection status (address 1) sets bit 0 on an instruction-side violation, bit 1 on a data-side violation, bit 3 on an unstacking error and bit 4 on a stacking error.
- R5: Bus status (address 2) sets bit 0 on a bus error response.
- R6: The exception output is registered. In the cycle after an event of an enabled class, `exc_valid` is 1 and `exc_num` is 4 (protection), 5 (bus) or 6 (usage). Enables are bit 16 (protection), bit 17 (bus) and bit 18 (usage) of address 5. While `exc_valid` is 0, `exc_num` is 0.
- R7: An event whose class enable is 0 raises exception 3 (hard fault). Its status flag is still set.
- R8: When several events arrive in the same cycle, hard fault wins, then 4, then 5, then 6.
- R9: Status flags are sticky. A privileged write clears each flag whose data bit is 1. If a new event and its clear arrive in the same cycle, the flag stays set.
- R10: A data-side violation sets bit 7 of address 1 and captures its address into address 3, but only while bit 7 is clear or is being cleared in that cycle. Otherwise the held address is kept.
- R11: A register write with `reg_priv` low, or an event on `ev_scs_unpriv`, raises exception 3 in the next cycle. Such a write changes no register.
- R12: A branch or return target reported with its least significant bit 0 sets usage bit 1 and counts as a usage fault. A target with that bit 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_undef | input | 1 | Undefined opcode event |
| ev_badstate | input | 1 | Invalid state event |
| ev_badret | input | 1 | Invalid exception-return token event |
| ev_copro | input | 1 | Coprocessor use event |
| ev_unalign | input | 1 | Misaligned access event |
| ev_divzero | input | 1 | Integer division by zero |
| ev_iacc | input | 1 | Instruction-side protection violation |
| ev_dacc | input | 1 | Data-side protection violation |
| ev_dacc_addr | input | AW | Address of the data-side violation |
| ev_unstk | input | 1 | Protection violation while restoring context |
| ev_stk | input | 1 | Protection violation while saving context |
| ev_buserr | input | 1 | Bus error response |
| ev_scs_unpriv | input | 1 | Unprivileged access to system control space |
| tgt_valid | input | 1 | A branch or return target is being reported |
| tgt_lsb | input | 1 | Least significant bit of that target |
| reg_wr | input | 1 | Register write strobe |
| reg_priv | input | 1 | Register access is privileged |
| reg_addr | input | RAW | Register address (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| exc_valid | output | 1 | An exception is to be raised |
| exc_num | output | 8 | Exception number to raise |

## Verification
Each event is driven alone, both with its class enabled and with it disabled. This separates the correct exception number from escalation to hard fault, and shows that the status flag is set in both cases. Division by zero and the branch-target bit are each tried in both states of their gating condition, so a missing or inverted gate shows up. Directed collisions follow: several classes in one cycle, an event together with its own clear, and a second data violation while an address is held. These expose priority order, clear-versus-set precedence and address overwrite. A long stretch of random events, privileged and unprivileged writes, and random read addresses is then compared each cycle against a behavioural model. This catches interactions that the directed cases do not reach.

// File: rtl/fault_escalator.sv
module fault_escalator #(
  parameter int AW  = 32,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_undef,
  input  logic           ev_badstate,
  input  logic           ev_badret,
  input  logic           ev_copro,
  input  logic           ev_unalign,
  input  logic           ev_divzero,
  input  logic           ev_iacc,
  input  logic           ev_dacc,
  input  logic [AW-1:0]  ev_dacc_addr,
  input  logic           ev_unstk,
  input  logic           ev_stk,
  input  logic           ev_buserr,
  input  logic           ev_scs_unpriv,
  input  logic           tgt_valid,
  input  logic           tgt_lsb,
  input  logic           reg_wr,
  input  logic           reg_priv,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           exc_valid,
  output logic [7:0]     exc_num
);

  localparam logic [RAW-1:0] A_USTAT = RAW'(0);
  localparam logic [RAW-1:0] A_MSTAT = RAW'(1);
  localparam logic [RAW-1:0] A_BSTAT = RAW'(2);
  localparam logic [RAW-1:0] A_FADDR = RAW'(3);
  localparam logic [RAW-1:0] A_TRAP  = RAW'(4);
  localparam logic [RAW-1:0] A_ENAB  = RAW'(5);

  localparam int U_UNDEF = 0, U_STATE = 1, U_RET = 2, U_COP = 3, U_ALIGN = 8, U_DIVZ = 9;
  localparam int M_IACC = 0, M_DACC = 1, M_UNSTK = 3, M_STK = 4, M_AVALID = 7;
  localparam int B_ERR = 0;
  localparam int T_DIVZ = 4;
  localparam int E_MEM = 16, E_BUS = 17, E_USE = 18;

  localparam logic [7:0] X_HARD = 8'd3, X_MEM = 8'd4, X_BUS = 8'd5, X_USE = 8'd6;

  logic [31:0]   us_q, ms_q, bs_q;
  logic [AW-1:0] fa_q;
  logic          trap_q;
  logic          en_mem_q, en_bus_q, en_use_q;

  logic          wr_ok, wr_bad;
  logic [31:0]   us_set, ms_set, bs_set;
  logic [31:0]   us_clr, ms_clr, bs_clr;
  logic          mem_hit, bus_hit, use_hit, hard_hit;
  logic          fa_load;

  assign wr_ok  = reg_wr &  reg_priv;
  assign wr_bad = reg_wr & ~reg_priv;

  assign us_clr = (wr_ok && reg_addr == A_USTAT) ? reg_wdata : '0;
  assign ms_clr = (wr_ok && reg_addr == A_MSTAT) ? reg_wdata : '0;
  assign bs_clr = (wr_ok && reg_addr == A_BSTAT) ? reg_wdata : '0;

  always_comb begin
    us_set = '0;
    us_set[U_UNDEF] = ev_undef;
    us_set[U_STATE] = ev_badstate | (tgt_valid & ~tgt_lsb);
    us_set[U_RET]   = ev_badret;
    us_set[U_COP]   = ev_copro;
    us_set[U_ALIGN] = ev_unalign;
    us_set[U_DIVZ]  = ev_divzero & trap_q;
    ms_set = '0;
    ms_set[M_IACC]   = ev_iacc;
    ms_set[M_DACC]   = ev_dacc;
    ms_set[M_UNSTK]  = ev_unstk;
    ms_set[M_STK]    = ev_stk;
    ms_set[M_AVALID] = ev_dacc;
    bs_set = '0;
    bs_set[B_ERR] = ev_buserr;
  end

  assign mem_hit  = |ms_set;
  assign bus_hit  = |bs_set;
  assign use_hit  = |us_set;
  assign hard_hit = wr_bad | ev_scs_unpriv
                  | (mem_hit & ~en_mem_q)
                  | (bus_hit & ~en_bus_q)
                  | (use_hit & ~en_use_q);

  assign fa_load = ev_dacc & (~ms_q[M_AVALID] | ms_clr[M_AVALID]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_q <= '0;
      ms_q <= '0;
      bs_q <= '0;
      fa_q <= '0;
    end else begin
      us_q <= (us_q & ~us_clr) | us_set;
      ms_q <= (ms_q & ~ms_clr) | ms_set;
      bs_q <= (bs_q & ~bs_clr) | bs_set;
      if (fa_load) fa_q <= ev_dacc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q   <= 1'b0;
      en_mem_q <= 1'b0;
      en_bus_q <= 1'b0;
      en_use_q <= 1'b0;
    end else if (wr_ok) begin
      if (reg_addr == A_TRAP) trap_q <= reg_wdata[T_DIVZ];
      if (reg_addr == A_ENAB) begin
        en_mem_q <= reg_wdata[E_MEM];
        en_bus_q <= reg_wdata[E_BUS];
        en_use_q <= reg_wdata[E_USE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_num   <= '0;
    end else begin
      exc_valid <= hard_hit | mem_hit | bus_hit | use_hit;
      exc_num   <= hard_hit ? X_HARD :
                   mem_hit  ? X_MEM  :
                   bus_hit  ? X_BUS  :
                   use_hit  ? X_USE  : 8'd0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_USTAT: reg_rdata = us_q;
      A_MSTAT: reg_rdata = ms_q;
      A_BSTAT: reg_rdata = bs_q;
      A_FADDR: reg_rdata = 32'(fa_q);
      A_TRAP:  reg_rdata[T_DIVZ] = trap_q;
      A_ENAB: begin
        reg_rdata[E_MEM] = en_mem_q;
        reg_rdata[E_BUS] = en_bus_q;
        reg_rdata[E_USE] = en_use_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  p_num_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_num >= X_HARD && exc_num <= X_USE));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> exc_num == 8'd0);

  p_unpriv_hard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_priv) |=> (exc_valid && exc_num == X_HARD));

  p_bus_escalate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buserr && !en_bus_q) |=> (exc_valid && exc_num == X_HARD));

  p_divz_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_divzero && !trap_q && !(wr_ok && reg_addr == A_USTAT)) |=> us_q[U_DIVZ] == $past(us_q[U_DIVZ]));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && reg_addr == A_USTAT) |=> (us_q & $past(us_q)) == $past(us_q));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_q[M_AVALID] && !(wr_ok && reg_addr == A_MSTAT)) |=> fa_q == $past(fa_q));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buserr |=> bs_q[B_ERR]);

endmodule

// File: tb/tb_fault_escalator.sv
`timescale 1ns/1ps
module tb_fault_escalator;
  localparam int AW = 32;
  localparam int RAW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_undef, ev_badstate, ev_badret, ev_copro, ev_unalign, ev_divzero;
  logic ev_iacc, ev_dacc, ev_unstk, ev_stk, ev_buserr, ev_scs_unpriv;
  logic [AW-1:0] ev_dacc_addr;
  logic tgt_valid, tgt_lsb, reg_wr, reg_priv;
  logic [RAW-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic exc_valid;
  logic [7:0] exc_num;

  always #4 clk = ~clk;

  fault_escalator #(.AW(AW), .RAW(RAW)) dut (.*);

  logic [31:0] m_us, m_ms, m_bs, m_fa;
  logic m_trap, m_emem, m_ebus, m_euse, m_xv;
  logic [7:0] m_xn;
  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_us = 0; m_ms = 0; m_bs = 0; m_fa = 0;
      m_trap = 0; m_emem = 0; m_ebus = 0; m_euse = 0; m_xv = 0; m_xn = 0;
    end else begin
      logic [31:0] su, sm, sb, cu, cm, cb;
      logic ok, hard, fm, fb, fu;
      ok = reg_wr && reg_priv;
      su = 0; sm = 0; sb = 0;
      if (ev_undef) su[0] = 1;
      if (ev_badstate || (tgt_valid && !tgt_lsb)) su[1] = 1;
      if (ev_badret) su[2] = 1;
      if (ev_copro) su[3] = 1;
      if (ev_unalign) su[8] = 1;
      if (ev_divzero && m_trap) su[9] = 1;
      if (ev_iacc) sm[0] = 1;
      if (ev_dacc) begin sm[1] = 1; sm[7] = 1; end
      if (ev_unstk) sm[3] = 1;
      if (ev_stk) sm[4] = 1;
      if (ev_buserr) sb[0] = 1;
      cu = (ok && reg_addr == 0) ? reg_wdata : 0;
      cm = (ok && reg_addr == 1) ? reg_wdata : 0;
      cb = (ok && reg_addr == 2) ? reg_wdata : 0;
      fm = sm != 0; fb = sb != 0; fu = su != 0;
      hard = (reg_wr && !reg_priv) || ev_scs_unpriv ||
             (fm && !m_emem) || (fb && !m_ebus) || (fu && !m_euse);
      m_xv = hard || fm || fb || fu;
      m_xn = hard ? 3 : fm ? 4 : fb ? 5 : fu ? 6 : 0;
      if (ev_dacc && (!m_ms[7] || cm[7])) m_fa = ev_dacc_addr;
      m_us = (m_us & ~cu) | su;
      m_ms = (m_ms & ~cm) | sm;
      m_bs = (m_bs & ~cb) | sb;
      if (ok && reg_addr == 4) m_trap = reg_wdata[4];
      if (ok && reg_addr == 5) begin
        m_emem = reg_wdata[16]; m_ebus = reg_wdata[17]; m_euse = reg_wdata[18];
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [RAW-1:0] a);
    case (a)
      0: return m_us;
      1: return m_ms;
      2: return m_bs;
      3: return m_fa;
      4: return {27'b0, m_trap, 4'b0};
      5: return {13'b0, m_euse, m_ebus, m_emem, 16'b0};
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (exc_valid !== m_xv || exc_num !== m_xn) begin
        mismatched++;
        $display("FAIL %s exception got %0b/%0d expected %0b/%0d", cur_req, exc_valid, exc_num, m_xv, m_xn);
      end
      compared++;
      if (reg_rdata !== m_read(reg_addr)) begin
        mismatched++;
        $display("FAIL %s read addr %0d got %h expected %h", cur_req, reg_addr, reg_rdata, m_read(reg_addr));
      end
    end
  end

  task automatic quiet();
    {ev_undef, ev_badstate, ev_badret, ev_copro, ev_unalign, ev_divzero} = '0;
    {ev_iacc, ev_dacc, ev_unstk, ev_stk, ev_buserr, ev_scs_unpriv} = '0;
    tgt_valid = 0; tgt_lsb = 1; reg_wr = 0; reg_priv = 1;
  endtask

  task automatic tick();
    @(posedge clk); #2; quiet();
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    reg_wr = 1; reg_priv = 1; reg_addr = RAW'(a); reg_wdata = d; tick();
  endtask

  task automatic look(input int a);
    reg_addr = RAW'(a); tick();
  endtask

  localparam logic [31:0] ALL_EN = 32'h0007_0000;

  initial begin
    quiet(); reg_addr = 0; reg_wdata = 0; ev_dacc_addr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cur_req = "R1";
    for (int a = 0; a < 8; a++) look(a);

    cur_req = "R2";
    wreg(5, ALL_EN);
    reg_addr = 0;
    ev_undef = 1; tick(); tick();
    ev_badstate = 1; tick(); tick();
    ev_badret = 1; tick(); tick();
    ev_copro = 1; tick(); tick();
    ev_unalign = 1; tick(); tick();
    wreg(0, 32'hFFFF_FFFF); look(0);

    cur_req = "R12";
    tgt_valid = 1; tgt_lsb = 1; tick(); tick();
    tgt_valid = 1; tgt_lsb = 0; tick(); tick();
    wreg(0, 32'h2); look(0);

    cur_req = "R3";
    ev_divzero = 1; tick(); tick();
    wreg(4, 32'h10); reg_addr = 0;
    ev_divzero = 1; tick(); tick();
    wreg(4, 0); reg_addr = 0;

    cur_req = "R9";
    reg_wr = 1; reg_priv = 1; reg_addr = 0; reg_wdata = 32'h301; ev_unalign = 1; tick();
    look(0);
    wreg(0, 32'h100); look(0);
    wreg(0, 32'hFFFF_FFFF); look(0);

    cur_req = "R4";
    reg_addr = 1;
    ev_iacc = 1; tick(); tick();
    ev_unstk = 1; tick(); tick();
    ev_stk = 1; tick(); tick();

    cur_req = "R10";
    ev_dacc = 1; ev_dacc_addr = 32'h2000_00F0; tick(); look(3);
    ev_dacc = 1; ev_dacc_addr = 32'h1234_5678; tick(); look(3);
    reg_wr = 1; reg_addr = 1; reg_wdata = 32'h80; ev_dacc = 1; ev_dacc_addr = 32'hCAFE_0004; tick();
    look(3); look(1);
    wreg(1, 32'h80); ev_dacc = 1; ev_dacc_addr = 32'h0BAD_F00C; tick(); look(3);
    wreg(1, 32'hFF); look(1);

    cur_req = "R5";
    reg_addr = 2; ev_buserr = 1; tick(); tick();
    wreg(2, 1); look(2);

    cur_req = "R7";
    wreg(5, 0); reg_addr = 0;
    ev_undef = 1; tick(); tick();
    ev_buserr = 1; tick(); tick();
    ev_iacc = 1; tick(); tick();
    wreg(5, 32'h0001_0000);
    ev_iacc = 1; ev_unalign = 1; tick(); tick();

    cur_req = "R8";
    wreg(5, ALL_EN);
    ev_copro = 1; ev_buserr = 1; tick(); tick();
    ev_copro = 1; ev_buserr = 1; ev_stk = 1; tick(); tick();
    ev_copro = 1; ev_scs_unpriv = 1; tick(); tick();

    cur_req = "R11";
    reg_wr = 1; reg_priv = 0; reg_addr = 5; reg_wdata = 0; tick(); look(5);
    reg_wr = 1; reg_priv = 0; reg_addr = 2; reg_wdata = 32'hFFFF_FFFF; tick(); look(2);
    ev_scs_unpriv = 1; tick(); tick();

    cur_req = "R6";
    for (int i = 0; i < 2500; i++) begin
      ev_undef = ($urandom % 10) == 0; ev_badstate = ($urandom % 12) == 0;
      ev_badret = ($urandom % 14) == 0; ev_copro = ($urandom % 12) == 0;
      ev_unalign = ($urandom % 10) == 0; ev_divzero = ($urandom % 8) == 0;
      ev_iacc = ($urandom % 14) == 0; ev_dacc = ($urandom % 9) == 0;
      ev_dacc_addr = $urandom; ev_unstk = ($urandom % 16) == 0;
      ev_stk = ($urandom % 16) == 0; ev_buserr = ($urandom % 11) == 0;
      ev_scs_unpriv = ($urandom % 30) == 0;
      tgt_valid = ($urandom % 6) == 0; tgt_lsb = $urandom;
      reg_wr = ($urandom % 5) == 0; reg_priv = ($urandom % 8) != 0;
      reg_addr = RAW'($urandom); reg_wdata = $urandom;
      @(posedge clk); #2;
    end
    quiet(); tick();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL %s watchdog expired", cur_req);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule